// File: doc/BRIEF.md
# JTAG User Scan Data Register

This block is a scan data register on the fabric side of a TAP bridge. It serves one user instruction. It runs entirely on the test clock and uses four signals from the bridge: the instruction's chip-enable, the shift indication, the update strobe, and a copy of TDI that the bridge has already registered on the rising clock edge. In the capture phase it loads a parallel status word. In the shift phase it moves serial data through the register, least significant bit first. On update it presents the shifted-in word as a parallel control word.

The serial output comes straight from bit 0 of the shift register. It therefore settles shortly after each rising edge, well before the falling edge on which the bridge samples it for TDO. The register width is a parameter with a default of 32. A scan longer or shorter than that width leaves the contents misaligned and raises no flag. The block does not decode TAP states and does not move its results into any other clock domain.

Top module: `jscan_user_dr`

## Requirements
- R1: On a rising edge with `rst_n` low, both the shift register and `ctrl_out` become all zeros, so `tdo_bit` reads 0 after that edge.
- R2: On a rising edge with `ce` high and `shift_en` low (capture), the shift register loads `status_in`, and `tdo_bit` then equals `status_in[0]`.
- R3: On a rising edge with `ce` and `shift_en` both high, the register shifts right by one. `tdi_q` enters bit W-1 and `tdo_bit` then shows the former bit 1. Scanning W bits after a capture returns `status_in` on `tdo_bit`, least significant bit first.
- R4: While `ce` is low, `shift_en` and `tdi_q` have no effect: the shift register keeps its value, as seen on `tdo_bit` and through a later update.
- R5: On a rising edge with `update_en` high, `ctrl_out` takes the shift register value from before that edge. The value of `ce` does not matter. With `update_en` low, `ctrl_out` holds its value.
- R6: When capture and update fall on the same edge, `ctrl_out` receives the contents from before the capture, while the shift register takes `status_in`.
- R7: A scan of fewer than W shift cycles leaves the shift register holding the new bits in its upper positions above the remaining upper bits of the earlier contents, and an update presents that misaligned word unchanged. A scan of more than W cycles keeps only the last W bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock from the bridge; every state change happens on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset, tied to the bridge's TAP reset strobe |
| ce | input | 1 | Chip-enable for this instruction; high during the capture and shift states |
| shift_en | input | 1 | High while the TAP is in the shift state |
| update_en | input | 1 | High while the TAP is in the update state |
| tdi_q | input | 1 | Serial input bit, already registered by the bridge |
| status_in | input | W | Parallel word loaded at capture |
| tdo_bit | output | 1 | Serial output (bit 0 of the shift register), sampled by the bridge on the falling edge |
| ctrl_out | output | W | Parallel control word committed at update |

## Verification
A real TAP never raises the update strobe during capture. The bench can still drive `update_en` on the same edge as a capture (or a shift), and this is where the two functions meet. R6 requires that the committed word is the one from before that edge, not the freshly loaded status. The bench provokes this collision with a directed case and also lets it occur under random stimulus. Every outcome is judged against a reference model in the bench that computes the next shift contents and the committed word from the values in force before the edge.

// File: rtl/jscan_pkg.sv
// Package: shared types for the user scan data register.
// Assumes nothing beyond the test clock domain it is used in.
package jscan_pkg;

    // Per-edge action decoded from the bridge control inputs
    typedef struct packed {
        logic load;   // capture the parallel status word
        logic step;   // shift by one position
        logic commit; // copy the shift contents to the parallel output
    } jscan_op_t;

endpackage

// File: rtl/jscan_phase_decode.sv
// Module: jscan_phase_decode
// Turns the bridge's chip-enable, shift and update signals into one-hot-or-zero
// load/step requests plus an independent commit request.
// Assumes the bridge raises ce only during capture and shift states.
module jscan_phase_decode
    import jscan_pkg::*;
(
    input  logic      ce,
    input  logic      shift_en,
    input  logic      update_en,
    output jscan_op_t op
);

    // Capture is ce without shift; shift needs both; commit follows update alone
    always_comb begin
        op.load   = ce & ~shift_en;
        op.step   = ce &  shift_en;
        op.commit = update_en;
    end

endmodule

// File: rtl/jscan_shift_chain.sv
// Module: jscan_shift_chain
// Shift register that loads a parallel word or shifts right with a new MSB.
// Assumes load and step are never both high (guaranteed by the phase decode).
module jscan_shift_chain #(
    parameter int W = 32
) (
    input  logic         tck,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic         ser_in,
    input  logic [W-1:0] par_in,
    output logic [W-1:0] chain_q
);

    logic [W-1:0] shifted;

    // Width-dependent shift path: a single-bit chain just takes the new bit
    generate
        if (W == 1) begin : g_one
            assign shifted = ser_in;
        end else begin : g_many
            assign shifted = {ser_in, chain_q[W-1:1]};
        end
    endgenerate

    // Chain state: reset, capture or shift on the rising test clock edge
    always_ff @(posedge tck) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else if (load) begin
            chain_q <= par_in;
        end else if (step) begin
            chain_q <= shifted;
        end
    end

endmodule

// File: rtl/jscan_hold_reg.sv
// Module: jscan_hold_reg
// Parallel output register that commits the shift contents on request.
// Assumes the source word is the pre-edge shift register value.
module jscan_hold_reg #(
    parameter int W = 32
) (
    input  logic         tck,
    input  logic         rst_n,
    input  logic         commit,
    input  logic [W-1:0] src,
    output logic [W-1:0] hold_q
);

    // Hold state: cleared by reset, loaded on commit, otherwise unchanged
    always_ff @(posedge tck) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (commit) begin
            hold_q <= src;
        end
    end

endmodule

// File: rtl/jscan_user_dr.sv
// Module: jscan_user_dr (top)
// Fabric-side scan data register for one user instruction of a TAP bridge.
// Captures status_in, shifts LSB first from tdi_q to tdo_bit and commits to ctrl_out.
// Assumes tdi_q is already registered by the bridge and tdo_bit is sampled on the
// falling edge of tck, so a registered bit 0 is settled in time.
module jscan_user_dr
    import jscan_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         tck,
    input  logic         rst_n,
    input  logic         ce,
    input  logic         shift_en,
    input  logic         update_en,
    input  logic         tdi_q,
    input  logic [W-1:0] status_in,
    output logic         tdo_bit,
    output logic [W-1:0] ctrl_out
);

    jscan_op_t    op;
    logic [W-1:0] chain_q;

    jscan_phase_decode u_dec (
        .ce        (ce),
        .shift_en  (shift_en),
        .update_en (update_en),
        .op        (op)
    );

    jscan_shift_chain #(.W(W)) u_chain (
        .tck     (tck),
        .rst_n   (rst_n),
        .load    (op.load),
        .step    (op.step),
        .ser_in  (tdi_q),
        .par_in  (status_in),
        .chain_q (chain_q)
    );

    jscan_hold_reg #(.W(W)) u_hold (
        .tck    (tck),
        .rst_n  (rst_n),
        .commit (op.commit),
        .src    (chain_q),
        .hold_q (ctrl_out)
    );

    // Serial return bit comes straight from the chain LSB
    assign tdo_bit = chain_q[0];

endmodule

// File: rtl/jscan_user_dr_chk.sv
// Module: jscan_user_dr_chk
// Protocol checker bound to jscan_user_dr; observes ports and the shift chain.
module jscan_user_dr_chk #(
    parameter int W = 32
) (
    input logic         tck,
    input logic         rst_n,
    input logic         ce,
    input logic         shift_en,
    input logic         update_en,
    input logic         tdi_q,
    input logic [W-1:0] status_in,
    input logic         tdo_bit,
    input logic [W-1:0] ctrl_out,
    input logic [W-1:0] chain_q
);

    // R1: a reset edge leaves both registers cleared
    p_reset_clear_r1: assert property (@(posedge tck)
        !rst_n |=> (ctrl_out == '0 && tdo_bit == 1'b0));

    // R2: capture presents status bit 0 on the serial output
    p_capture_lsb_r2: assert property (@(posedge tck) disable iff (!rst_n)
        (ce && !shift_en) |=> (tdo_bit == $past(status_in[0])));

    // R3: the serial input lands in the MSB on a shift
    p_shift_msb_r3: assert property (@(posedge tck) disable iff (!rst_n)
        (ce && shift_en) |=> (chain_q[W-1] == $past(tdi_q)));

    generate
        if (W > 1) begin : g_wide
            // R3: the next serial output bit is the former bit 1
            p_shift_lsb_r3: assert property (@(posedge tck) disable iff (!rst_n)
                (ce && shift_en) |=> (tdo_bit == $past(chain_q[1])));
        end
    endgenerate

    // R4: without chip-enable the chain is frozen
    p_idle_frozen_r4: assert property (@(posedge tck) disable iff (!rst_n)
        !ce |=> $stable(chain_q));

    // R5 and R6: update commits the pre-edge chain contents
    p_commit_r5: assert property (@(posedge tck) disable iff (!rst_n)
        update_en |=> (ctrl_out == $past(chain_q)));

    // R5: without update the parallel output holds
    p_hold_r5: assert property (@(posedge tck) disable iff (!rst_n)
        !update_en |=> $stable(ctrl_out));

endmodule

bind jscan_user_dr jscan_user_dr_chk #(.W(W)) u_chk (
    .tck       (tck),
    .rst_n     (rst_n),
    .ce        (ce),
    .shift_en  (shift_en),
    .update_en (update_en),
    .tdi_q     (tdi_q),
    .status_in (status_in),
    .tdo_bit   (tdo_bit),
    .ctrl_out  (ctrl_out),
    .chain_q   (chain_q)
);

// File: tb/jscan_user_dr_tb_top.sv
// Bench for jscan_user_dr: directed corners plus seeded random phase stimulus,
// compared each cycle with a reference model held in bench functions.
module jscan_user_dr_tb_top;

    localparam int W = 32;
    localparam int RAND_CYCLES = 4000;
    localparam int WATCHDOG_CYCLES = 100000;

    logic         tck = 1'b0;
    logic         rst_n, ce, shift_en, update_en, tdi_q;
    logic [W-1:0] status_in;
    logic         tdo_bit;
    logic [W-1:0] ctrl_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [W-1:0] m_chain = '0;
    logic [W-1:0] m_out = '0;

    always #10 tck = ~tck;

    jscan_user_dr #(.W(W)) dut_i (
        .tck       (tck),
        .rst_n     (rst_n),
        .ce        (ce),
        .shift_en  (shift_en),
        .update_en (update_en),
        .tdi_q     (tdi_q),
        .status_in (status_in),
        .tdo_bit   (tdo_bit),
        .ctrl_out  (ctrl_out)
    );

    // Reference next-chain value from the requirements
    function automatic logic [W-1:0] ref_chain(logic r, logic c, logic s, logic t,
                                               logic [W-1:0] st, logic [W-1:0] cur);
        if (!r) return '0;
        if (c && !s) return st;
        if (c && s) return {t, cur[W-1:1]};
        return cur;
    endfunction

    // Reference next-output value from the requirements
    function automatic logic [W-1:0] ref_out(logic r, logic u, logic [W-1:0] cur_chain,
                                             logic [W-1:0] cur_out);
        if (!r) return '0;
        if (u) return cur_chain;
        return cur_out;
    endfunction

    task automatic check_bit(string tag, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: tdo_bit actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic check_word(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: ctrl_out actual %h expected %h", tag, act, exp);
        end
    endtask

    // Apply one cycle of inputs from a falling edge, then check after the rising edge
    task automatic step(logic r, logic c, logic s, logic u, logic t, string tag);
        logic [W-1:0] nc, no;
        rst_n = r; ce = c; shift_en = s; update_en = u; tdi_q = t;
        nc = ref_chain(r, c, s, t, status_in, m_chain);
        no = ref_out(r, u, m_chain, m_out);
        @(posedge tck);
        m_chain = nc;
        m_out = no;
        @(negedge tck);
        check_bit(tag, tdo_bit, m_chain[0]);
        check_word(tag, ctrl_out, m_out);
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge tck);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] word, got;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; ce = 1'b0; shift_en = 1'b0; update_en = 1'b0; tdi_q = 1'b0;
        status_in = '0;
        @(negedge tck);

        // R1: reset clears everything
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R1");
        step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, "R1");

        // R2 + R3: capture then full scan returns status LSB first
        status_in = 32'hA5C3_0F96;
        step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R2");
        for (int i = 0; i < W; i++) begin
            n_chk++;
            if (tdo_bit !== status_in[i]) begin
                n_fail++;
                $display("FAIL R3: bit %0d actual %0b expected %0b", i, tdo_bit, status_in[i]);
            end
            step(1'b1, 1'b1, 1'b1, 1'b0, 1'(i % 3 == 0), "R3");
        end

        // R5: commit the shifted word and hold afterwards
        step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R5");
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R5");

        // R4: shift_en and tdi_q ignored while ce is low, confirmed via update
        word = m_chain;
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "R4");
        step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R4");
        check_word("R4", ctrl_out, word);

        // R6: capture and update on the same edge
        word = m_chain;
        status_in = 32'h1234_5678;
        step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R6");
        check_word("R6", ctrl_out, word);
        check_bit("R6", tdo_bit, 1'b0);

        // R7: short scan of W-4 ones after capture, then update
        status_in = 32'hF00D_BEEF;
        step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R7");
        for (int i = 0; i < W - 4; i++) step(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, "R7");
        step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R7");
        got = {{(W-4){1'b1}}, 4'hF};
        check_word("R7", ctrl_out, got);

        // R7: long scan of W+3 bits keeps only the last W
        status_in = '0;
        step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R7");
        for (int i = 0; i < W + 3; i++) step(1'b1, 1'b1, 1'b1, 1'b0, 1'(i >= 3), "R7");
        step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R7");
        check_word("R7", ctrl_out, '1);

        // Random phase mix, including update colliding with capture or shift (R6)
        for (int i = 0; i < RAND_CYCLES; i++) begin
            status_in = $urandom;
            step(($urandom % 64) != 0, ($urandom % 4) != 0, ($urandom % 3) != 0,
                 ($urandom % 6) == 0, 1'($urandom), "R3/R5/R6 random");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule